// File: doc/BRIEF.md
# Integer Threshold Gate Unit

This block evaluates a single threshold neuron over eight binary inputs. Each input that is high adds its signed integer weight to a running total. The total starts from a signed integer bias. The output goes high when the total is zero or positive. A hard step is the only activation, and all arithmetic is on integers.

A function select chooses where the weights and bias come from. They can come from a configuration port, from module parameters, or from a built-in preset table. The presets cover AND, OR, NOT, NAND, NOR, at-least-k, majority, minority and exactly-k. The preset functions work only over the inputs enabled by a participation mask, and `n` is the number of mask bits that are set. Exactly-k is not linearly separable, so it is built from two first-layer neurons feeding a second-layer neuron.

The unit is purely combinational, with no clock and no reset. It has no data stream, so it needs no handshake. The output follows the inputs after logic settling, and callers register it wherever their pipeline needs it.

Top module: `thg_unit`

## Requirements
- R1: With `fn_sel`=0 (configured), `y` is 1 exactly when the bias plus the sum of the weights of the high inputs is ≥ 0, and is 0 otherwise. Input i's weight is the 4-bit two's-complement field `cfg_weights[4i+3:4i]`, and the bias is the 6-bit two's-complement `cfg_bias`. The mask is ignored in this mode.
- R2: The sum never wraps. Eight weights of 7 with a bias of 31 give 1. Eight weights of -8 with a bias of -32 give 0. Eight weights of -8 with a bias of 31 give 0.
- R3: With `fn_sel`=1 (fixed), the weights and bias come from the parameters `FIX_WEIGHTS` and `FIX_BIAS`. By default every weight is 1 and the bias is -4, so the function is "at least four of the eight inputs high".
- R4: With `fn_sel`=2 (AND), `y`=1 when every masked input is high. With `fn_sel`=5 (NAND), `y` is the inverse of that. With an empty mask, AND gives 1 and NAND gives 0.
- R5: With `fn_sel`=3 (OR), `y`=1 when any masked input is high. With `fn_sel`=6 (NOR), `y` is the inverse of that.
- R6: With `fn_sel`=4 (NOT), `y` is the inverse of `x[0]`. The mask and the other inputs are ignored.
- R7: With `fn_sel`=7 (at-least-k), `y`=1 when the count of high masked inputs is ≥ `k`. With `k`=0, `y` is always 1. With `k` greater than `n`, `y` is always 0.
- R8: With `fn_sel`=8 (majority), `y`=1 when twice the count of high masked inputs exceeds `n`. For odd `n` this is the same as a count of at least ceil(n/2).
- R9: With `fn_sel`=9 (minority), `y`=1 when twice the count of high masked inputs is less than `n`. An empty mask gives 0.
- R10: With `fn_sel`=10 (exactly-k), `y`=1 when the count of high masked inputs equals `k`. The result is formed by a second-layer neuron over two at-least neurons set to `k` and `k+1`.
- R11: `fn_sel` codes 11 to 15 give `y`=0 for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x | input | 8 | Binary inputs to the neuron |
| in_mask | input | 8 | Inputs that take part in the preset functions |
| fn_sel | input | 4 | Function select (codes listed in R1 to R11) |
| k | input | 4 | Count threshold for at-least-k and exactly-k |
| cfg_weights | input | 32 | Eight 4-bit signed weights, input i at bits [4i+3:4i] |
| cfg_bias | input | 6 | Signed bias for the configured mode |
| y | output | 1 | Step output of the selected neuron network |

## Verification
The immediate assertions inside the logic assume that all inputs hold one settled value while they are evaluated. A glitch between two input sets is not a valid state for them. The bench therefore changes every input together, once per cycle on the falling clock edge, and compares the output on the following rising edge. The stimulus keeps `k` within its 4-bit range. It walks every input pattern under full, odd-sized, even-sized and empty masks, so that the majority and minority boundaries at exactly half are reached.

// File: rtl/thg_pkg.sv
package thg_pkg;

  typedef enum logic [3:0] {
    FN_CFG     = 4'd0,
    FN_FIXED   = 4'd1,
    FN_AND     = 4'd2,
    FN_OR      = 4'd3,
    FN_NOT     = 4'd4,
    FN_NAND    = 4'd5,
    FN_NOR     = 4'd6,
    FN_ATLEAST = 4'd7,
    FN_MAJ     = 4'd8,
    FN_MIN     = 4'd9,
    FN_EXACT   = 4'd10
  } fn_e;

  // Signed width that holds n weights of ww bits plus a bw-bit bias.
  function automatic int unsigned acc_width(int unsigned n, int unsigned ww,
                                            int unsigned bw);
    int unsigned a;
    a = ww + $clog2(n + 1);
    return ((a > bw) ? a : bw) + 1;
  endfunction

endpackage

// File: rtl/thg_neuron.sv
module thg_neuron #(
  parameter int unsigned N  = 8,
  parameter int unsigned WW = 4,
  parameter int unsigned BW = 6
) (
  input  logic [N-1:0]        x,
  input  logic [N*WW-1:0]     w_flat,
  input  logic signed [BW-1:0] bias,
  output logic                fire
);
  localparam int unsigned SW = thg_pkg::acc_width(N, WW, BW);

  logic signed [SW-1:0] acc;

  always_comb begin
    acc = {{(SW-BW){bias[BW-1]}}, bias};
    for (int i = 0; i < N; i++) begin
      if (x[i]) begin
        acc = acc + {{(SW-WW){w_flat[i*WW+WW-1]}}, w_flat[i*WW +: WW]};
      end
    end
  end

  assign fire = ~acc[SW-1];

  // Checks: zero input reduces to the bias sign; no wrap when all terms are non-negative.
  logic all_nonneg;
  always_comb begin
    all_nonneg = ~bias[BW-1];
    for (int i = 0; i < N; i++) begin
      if (x[i] && w_flat[i*WW+WW-1]) all_nonneg = 1'b0;
    end
  end

  always_comb begin
    if (x == '0) begin
      a_r1_zero_input: assert (fire == ~bias[BW-1])
        else $error("zero input must follow bias sign");
    end
    if (all_nonneg) begin
      a_r2_no_overflow: assert (fire)
        else $error("non-negative terms produced a negative sum");
    end
  end

endmodule

// File: rtl/thg_preset.sv
module thg_preset #(
  parameter int unsigned          N       = 8,
  parameter int unsigned          WW      = 4,
  parameter int unsigned          BW      = 6,
  parameter int unsigned          KW      = 4,
  parameter logic [N*WW-1:0]      FIX_W   = '0,
  parameter logic signed [BW-1:0] FIX_B   = '0
) (
  input  logic [3:0]          fn_sel,
  input  logic [N-1:0]        in_mask,
  input  logic [KW-1:0]       k,
  input  logic [N*WW-1:0]     cfg_weights,
  input  logic signed [BW-1:0] cfg_bias,
  output logic [N*WW-1:0]     w_a,
  output logic signed [BW-1:0] b_a,
  output logic [N*WW-1:0]     w_b,
  output logic signed [BW-1:0] b_b,
  output logic                use_l2
);
  import thg_pkg::*;

  localparam logic [WW-1:0] W_POS = WW'(1);
  localparam logic [WW-1:0] W_NEG = WW'(-1);

  function automatic logic [N*WW-1:0] spread(input logic [N-1:0] m,
                                             input logic [WW-1:0] v);
    logic [N*WW-1:0] r;
    for (int i = 0; i < N; i++) r[i*WW +: WW] = m[i] ? v : '0;
    return r;
  endfunction

  always_comb begin
    int n;
    int kv;
    n      = $countones(in_mask);
    kv     = int'(k);
    w_a    = '0;
    b_a    = BW'(-1);
    w_b    = '0;
    b_b    = BW'(-1);
    use_l2 = 1'b0;
    case (fn_sel)
      FN_CFG:     begin w_a = cfg_weights; b_a = cfg_bias; end
      FN_FIXED:   begin w_a = FIX_W; b_a = FIX_B; end
      FN_AND:     begin w_a = spread(in_mask, W_POS); b_a = BW'(-n); end
      FN_OR:      begin w_a = spread(in_mask, W_POS); b_a = BW'(-1); end
      FN_NOT:     begin w_a = spread(N'(1), W_NEG); b_a = '0; end
      FN_NAND:    begin w_a = spread(in_mask, W_NEG); b_a = BW'(n - 1); end
      FN_NOR:     begin w_a = spread(in_mask, W_NEG); b_a = '0; end
      FN_ATLEAST: begin w_a = spread(in_mask, W_POS); b_a = BW'(-kv); end
      FN_MAJ:     begin w_a = spread(in_mask, W_POS); b_a = BW'(-(n / 2 + 1)); end
      FN_MIN: begin
        w_a = spread(in_mask, W_NEG);
        b_a = (n == 0) ? BW'(-1) : BW'((n - 1) / 2);
      end
      FN_EXACT: begin
        w_a    = spread(in_mask, W_POS);
        b_a    = BW'(-kv);
        w_b    = spread(in_mask, W_POS);
        b_b    = BW'(-(kv + 1));
        use_l2 = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/thg_unit.sv
module thg_unit #(
  parameter int unsigned N_IN     = 8,
  parameter int unsigned WEIGHT_W = 4,
  parameter int unsigned BIAS_W   = 6,
  parameter logic [N_IN*WEIGHT_W-1:0] FIX_WEIGHTS = {N_IN{WEIGHT_W'(1)}},
  parameter logic signed [BIAS_W-1:0] FIX_BIAS    = BIAS_W'(-4)
) (
  input  logic [N_IN-1:0]            x,
  input  logic [N_IN-1:0]            in_mask,
  input  logic [3:0]                 fn_sel,
  input  logic [$clog2(N_IN+1)-1:0]  k,
  input  logic [N_IN*WEIGHT_W-1:0]   cfg_weights,
  input  logic [BIAS_W-1:0]          cfg_bias,
  output logic                       y
);
  import thg_pkg::*;

  localparam int unsigned KW = $clog2(N_IN + 1);
  localparam logic [2*WEIGHT_W-1:0] L2_W = {WEIGHT_W'(-1), WEIGHT_W'(1)};
  localparam logic [BIAS_W-1:0]     L2_B = BIAS_W'(-1);

  logic [N_IN*WEIGHT_W-1:0] w_l1 [2];
  logic [BIAS_W-1:0]        b_l1 [2];
  logic [1:0]               l1_fire;
  logic                     l2_fire;
  logic                     use_l2;

  thg_preset #(
    .N(N_IN), .WW(WEIGHT_W), .BW(BIAS_W), .KW(KW),
    .FIX_W(FIX_WEIGHTS), .FIX_B(FIX_BIAS)
  ) u_preset (
    .fn_sel(fn_sel), .in_mask(in_mask), .k(k),
    .cfg_weights(cfg_weights), .cfg_bias(cfg_bias),
    .w_a(w_l1[0]), .b_a(b_l1[0]), .w_b(w_l1[1]), .b_b(b_l1[1]),
    .use_l2(use_l2)
  );

  for (genvar g = 0; g < 2; g++) begin : g_layer1
    thg_neuron #(.N(N_IN), .WW(WEIGHT_W), .BW(BIAS_W)) u_neuron (
      .x(x), .w_flat(w_l1[g]), .bias(b_l1[g]), .fire(l1_fire[g])
    );
  end

  // Second layer: fires when "at least k" holds and "at least k+1" does not.
  thg_neuron #(.N(2), .WW(WEIGHT_W), .BW(BIAS_W)) u_layer2 (
    .x(l1_fire), .w_flat(L2_W), .bias(L2_B), .fire(l2_fire)
  );

  assign y = use_l2 ? l2_fire : l1_fire[0];

  always_comb begin
    if (fn_sel == FN_AND && (x & in_mask) == in_mask) begin
      a_r4_and_full: assert (y) else $error("AND of all-high masked inputs is 0");
    end
    if (fn_sel == FN_OR && (x & in_mask) == '0) begin
      a_r5_or_empty: assert (!y) else $error("OR with no high masked input is 1");
    end
    if (fn_sel == FN_ATLEAST && k == '0) begin
      a_r7_k_zero: assert (y) else $error("at-least-0 must be 1");
    end
    if (fn_sel == FN_EXACT && y) begin
      a_r10_exact_count: assert ($countones(x & in_mask) == int'(k))
        else $error("exactly-k fired with wrong count");
    end
    if (fn_sel > 4'd10) begin
      a_r11_unused_zero: assert (!y) else $error("unused code drove 1");
    end
  end

endmodule

// File: tb/thg_unit_test.sv
module thg_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  x = '0;
  logic [7:0]  in_mask = '0;
  logic [3:0]  fn_sel = 4'd2;
  logic [3:0]  k = '0;
  logic [31:0] cfg_weights = '0;
  logic [5:0]  cfg_bias = '0;
  logic        y;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  thg_unit uut (
    .x(x), .in_mask(in_mask), .fn_sel(fn_sel), .k(k),
    .cfg_weights(cfg_weights), .cfg_bias(cfg_bias), .y(y)
  );

  function automatic bit ref_y(logic [7:0] xv, logic [7:0] m, logic [3:0] f,
                               logic [3:0] kk, logic [31:0] w, logic [5:0] b);
    int c, n, s;
    c = $countones(xv & m);
    n = $countones(m);
    case (f)
      4'd0: begin
        s = $signed(b);
        for (int i = 0; i < 8; i++) if (xv[i]) s += $signed(w[4*i +: 4]);
        return s >= 0;
      end
      4'd1:  return $countones(xv) >= 4;
      4'd2:  return c == n;
      4'd3:  return c > 0;
      4'd4:  return !xv[0];
      4'd5:  return c != n;
      4'd6:  return c == 0;
      4'd7:  return c >= int'(kk);
      4'd8:  return 2 * c > n;
      4'd9:  return 2 * c < n;
      4'd10: return c == int'(kk);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string fn_tag(logic [3:0] f);
    case (f)
      4'd0: return "R1";
      4'd1: return "R3";
      4'd2, 4'd5: return "R4";
      4'd3, 4'd6: return "R5";
      4'd4: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic drive(logic [7:0] xv, logic [7:0] m, logic [3:0] f, logic [3:0] kk,
                       logic [31:0] w, logic [5:0] b, string tag);
    @(negedge clk);
    x = xv; in_mask = m; fn_sel = f; k = kk; cfg_weights = w; cfg_bias = b;
    exp_q.push_back(ref_y(xv, m, f, kk, w, b));
    tag_q.push_back(tag);
  endtask

  // Monitor: one comparison per rising edge, on inputs driven at the prior falling edge.
  initial begin
    forever begin
      @(posedge clk);
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (y !== e) begin
          failures++;
          $display("FAIL %s x=%h mask=%h fn=%0d k=%0d y=%b expected=%b",
                   t, x, in_mask, fn_sel, k, y, e);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle state: AND over an empty mask
    drive(8'h00, 8'h00, 4'd2, 4'd0, '0, '0, "R4");
    // R1: two-input AND built from weights 1,1 and bias -2
    for (int v = 0; v < 4; v++) drive(8'(v), 8'h00, 4'd0, 4'd0, 32'h0000_0011, 6'h3E, "R1");
    // R1: mask ignored in configured mode
    drive(8'h01, 8'h00, 4'd0, 4'd0, 32'h0000_0001, 6'h3F, "R1");
    for (int j = 0; j < 300; j++)
      drive(8'($urandom), 8'($urandom), 4'd0, 4'd0, $urandom, 6'($urandom), "R1");
    // R2: extremes of the accumulator
    drive(8'hFF, 8'hFF, 4'd0, 4'd0, 32'h7777_7777, 6'h1F, "R2");
    drive(8'hFF, 8'hFF, 4'd0, 4'd0, 32'h8888_8888, 6'h20, "R2");
    drive(8'hFF, 8'hFF, 4'd0, 4'd0, 32'h8888_8888, 6'h1F, "R2");
    drive(8'h00, 8'hFF, 4'd0, 4'd0, 32'h8888_8888, 6'h20, "R2");
    // R3: fixed parameters
    drive(8'h07, 8'h00, 4'd1, 4'd0, '0, '0, "R3");
    drive(8'h0F, 8'h00, 4'd1, 4'd0, '0, '0, "R3");
    // R6: other inputs and mask ignored
    drive(8'hFE, 8'h00, 4'd4, 4'd0, '0, '0, "R6");
    drive(8'h01, 8'hFF, 4'd4, 4'd0, '0, '0, "R6");
    // Boundaries for R7 to R10
    drive(8'h00, 8'hFF, 4'd7, 4'd0, '0, '0, "R7");
    drive(8'hFF, 8'hFF, 4'd7, 4'd9, '0, '0, "R7");
    drive(8'h03, 8'h0F, 4'd8, 4'd0, '0, '0, "R8");
    drive(8'h03, 8'h0F, 4'd9, 4'd0, '0, '0, "R9");
    drive(8'h00, 8'h00, 4'd9, 4'd0, '0, '0, "R9");
    drive(8'h00, 8'hFF, 4'd10, 4'd0, '0, '0, "R10");
    // Exhaustive walk over presets and masks
    for (int f = 2; f <= 10; f++) begin
      for (int mi = 0; mi < 4; mi++) begin
        logic [7:0] m;
        m = (mi == 0) ? 8'hFF : (mi == 1) ? 8'h0F : (mi == 2) ? 8'h07 : 8'h00;
        for (int v = 0; v < 256; v++)
          drive(8'(v), m, 4'(f), 4'((v * 7 + f) % 10), '0, '0, fn_tag(4'(f)));
      end
    end
    // R11: unused codes
    for (int f = 11; f < 16; f++)
      for (int j = 0; j < 20; j++)
        drive(8'($urandom), 8'($urandom), 4'(f), 4'($urandom), $urandom, 6'($urandom), "R11");
    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule